// File: doc/BRIEF.md
# Programmable-Flag Offset Register Loader

This block holds the two threshold offsets that a synchronous FIFO compares against its fill level to raise its almost-empty and almost-full flags. Both offsets are loaded either one bit per write-clock edge through a serial input, or over a narrow parallel data bus as a fixed four-step cycle of partial words. A strap pin chooses the method, and it is sampled only while master reset is held. The offsets can be read back over the parallel output bus in the same four-step order, whichever method is locked in. The two offset values are driven continuously to the flag logic, which sits outside this block.

The offsets live in the write-clock domain. The readback path runs on the read clock and treats the offsets as quasi-static configuration. Master reset is asynchronous and active low, and each clock domain releases it synchronously.

Top module: `ofs_loader`

## Requirements
- R1: The method is captured from `ser_sel` (1 = serial, 0 = parallel) while master reset is active. Changing `ser_sel` after reset has no effect until the next master reset.
- R2: After master reset, both offsets equal 127, `dout` is 0, and both part pointers point at the almost-empty low part.
- R3: In serial mode, each rising `wclk` edge with `cfg_n`=1, `shift_en_n`=0 and `wr_en_n`=1 shifts exactly one bit. The 28-bit chain {`af_ofs`,`ae_ofs`} moves one place toward the `af_ofs` MSB, `sdi` enters `ae_ofs[0]`, and the old `af_ofs[13]` is discarded.
- R4: No shift happens in parallel mode, when `wr_en_n`=0, or when `cfg_n`=0.
- R5: In parallel mode, a rising `wclk` edge with `cfg_n`=0 and `wr_en_n`=0 writes `din` into the part at the write pointer, then advances the pointer. The parts come in this order: `ae_ofs[8:0]`=`din[8:0]`, `ae_ofs[13:9]`=`din[4:0]`, `af_ofs[8:0]`=`din[8:0]`, `af_ofs[13:9]`=`din[4:0]`. After the fourth part the pointer wraps to the first. `din[8:5]` is ignored for the upper parts.
- R6: In serial mode, parallel writes leave both offsets unchanged.
- R7: In either mode, a rising `rclk` edge with `cfg_n`=0 and `rd_en_n`=0 loads `dout` with the part at the read pointer, then advances it. The order matches R5, and upper parts are zero-extended into `dout[8:5]`. After the fourth part the pointer wraps.
- R8: Any clock edge of a domain that samples `cfg_n`=1 returns that domain's pointer to the almost-empty low part.
- R9: `dout` holds its value on every `rclk` edge that is not a parallel read.
- R10: `ae_ofs` and `af_ofs` show the stored offsets continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; loads and shifts offsets |
| rclk | input | 1 | Read clock; parallel readback |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| ser_sel | input | 1 | Method strap sampled in reset: 1 serial, 0 parallel |
| cfg_n | input | 1 | Low selects offset access on the parallel bus |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| shift_en_n | input | 1 | Active-low serial shift enable |
| sdi | input | 1 | Serial data in |
| din | input | 9 | Parallel data in |
| dout | output | 9 | Parallel readback data |
| ae_ofs | output | 14 | Almost-empty offset |
| af_ofs | output | 14 | Almost-full offset |

## Verification
The bench sweeps several offset pairs through the four-part write and read cycles, and checks the chain after every single serial shift. If the part order were wrong, or the upper parts were not masked, the offsets would take the wrong bits. A chain shifting the wrong way, or dropping bits at the wrong end, fails the per-shift checks and the overrun test. Separate tests leave `cfg_n` low across a fifth access, and raise `cfg_n` partway through a cycle. A pointer that fails to wrap or to return home would then write or return the wrong part. Other tests flip `ser_sel` after reset and try the method that is not selected. A design that kept tracking the strap, or let both methods through, would change offsets that must stay put.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;

  typedef enum logic [1:0] {
    PART_AE_LO = 2'd0,
    PART_AE_HI = 2'd1,
    PART_AF_LO = 2'd2,
    PART_AF_HI = 2'd3
  } part_e;

  localparam int unsigned RESET_OFS = 127;

  function automatic part_e next_part(input part_e p);
    return part_e'(2'(p + 2'd1));
  endfunction

endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int BUS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_sel,
  input  logic             cfg_n,
  input  logic             wr_en_n,
  input  logic             shift_en_n,
  input  logic             sdi,
  input  logic [BUS_W-1:0] din,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             mode_ser
);
  localparam int CHAIN_W = 2 * OFS_W;
  localparam int HI_W    = OFS_W - BUS_W;
  localparam logic [OFS_W-1:0] RST_V = OFS_W'(RESET_OFS);

  logic [CHAIN_W-1:0] chain_q, chain_d;
  part_e              wptr_q, wptr_d;
  logic               mode_q;
  logic               par_wr, ser_sh, chain_en;

  always_comb begin
    par_wr   = !mode_q && !cfg_n && !wr_en_n;
    ser_sh   = mode_q && cfg_n && !shift_en_n && wr_en_n;
    chain_en = par_wr || ser_sh;
    chain_d  = chain_q;
    wptr_d   = wptr_q;
    if (ser_sh) chain_d = {chain_q[CHAIN_W-2:0], sdi};
    if (par_wr) begin
      unique case (wptr_q)
        PART_AE_LO: chain_d[BUS_W-1:0]               = din;
        PART_AE_HI: chain_d[OFS_W-1:BUS_W]           = din[HI_W-1:0];
        PART_AF_LO: chain_d[OFS_W+BUS_W-1:OFS_W]     = din;
        default:    chain_d[CHAIN_W-1:OFS_W+BUS_W]   = din[HI_W-1:0];
      endcase
      wptr_d = next_part(wptr_q);
    end
    if (cfg_n) wptr_d = PART_AE_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= {RST_V, RST_V};
    else if (chain_en) chain_q <= chain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= PART_AE_LO;
    else        wptr_q <= wptr_d;
  end

  // Strap capture: loads only while the synchronized reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ser_sel;
  end

  assign ae_ofs   = chain_q[OFS_W-1:0];
  assign af_ofs   = chain_q[CHAIN_W-1:OFS_W];
  assign mode_ser = mode_q;
endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
  import ofs_loader_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int BUS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_n,
  input  logic             rd_en_n,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic [BUS_W-1:0] dout
);
  localparam int NUM_OFS = 2;

  logic [OFS_W-1:0] ofs_sel  [NUM_OFS];
  logic [BUS_W-1:0] part_val [2*NUM_OFS];
  logic [BUS_W-1:0] dout_q, dout_d;
  part_e            rptr_q, rptr_d;
  logic             rd_go;

  assign ofs_sel[0] = ae_ofs;
  assign ofs_sel[1] = af_ofs;

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_parts
    assign part_val[2*g]   = ofs_sel[g][BUS_W-1:0];
    assign part_val[2*g+1] = BUS_W'(ofs_sel[g][OFS_W-1:BUS_W]);
  end

  always_comb begin
    rd_go  = !cfg_n && !rd_en_n;
    dout_d = part_val[rptr_q];
    rptr_d = rptr_q;
    if (rd_go) rptr_d = next_part(rptr_q);
    if (cfg_n) rptr_d = PART_AE_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout_q <= '0;
    else if (rd_go) dout_q <= dout_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rptr_q <= PART_AE_LO;
    else        rptr_q <= rptr_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader #(
  parameter int OFS_W = 14,
  parameter int BUS_W = 9
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst_n,
  input  logic             ser_sel,
  input  logic             cfg_n,
  input  logic             wr_en_n,
  input  logic             rd_en_n,
  input  logic             shift_en_n,
  input  logic             sdi,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  logic w_rst_n, r_rst_n, mode_ser;

  ofs_rst_sync #(.STAGES(2)) u_wsync (.clk(wclk), .arst_n(mrst_n), .rst_n(w_rst_n));
  ofs_rst_sync #(.STAGES(2)) u_rsync (.clk(rclk), .arst_n(mrst_n), .rst_n(r_rst_n));

  ofs_wr_side #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_wr (
    .clk(wclk), .rst_n(w_rst_n), .ser_sel(ser_sel), .cfg_n(cfg_n),
    .wr_en_n(wr_en_n), .shift_en_n(shift_en_n), .sdi(sdi), .din(din),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .mode_ser(mode_ser)
  );

  ofs_rd_side #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .cfg_n(cfg_n), .rd_en_n(rd_en_n),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout)
  );
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
  parameter int OFS_W = 14,
  parameter int BUS_W = 9
) (
  input logic             wclk,
  input logic             rclk,
  input logic             mrst_n,
  input logic             w_rst_n,
  input logic             r_rst_n,
  input logic             mode_ser,
  input logic             cfg_n,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic             shift_en_n,
  input logic             sdi,
  input logic [BUS_W-1:0] dout,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs
);
  p_mode_hold_r1: assert property (@(posedge wclk) disable iff (!mrst_n)
    w_rst_n |=> $stable(mode_ser));

  p_reset_val_r2: assert property (@(posedge wclk) disable iff (!mrst_n)
    $rose(w_rst_n) |-> (ae_ofs == OFS_W'(127) && af_ofs == OFS_W'(127)));

  p_shift_in_r3: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (mode_ser && cfg_n && !shift_en_n && wr_en_n) |=>
      (ae_ofs[0] == $past(sdi) && ae_ofs[OFS_W-1:1] == $past(ae_ofs[OFS_W-2:0])));

  p_no_shift_r4: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (!mode_ser && cfg_n) |=> $stable({af_ofs, ae_ofs}));

  p_par_blocked_r6: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (mode_ser && !cfg_n) |=> $stable({af_ofs, ae_ofs}));

  p_dout_hold_r9: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (cfg_n || rd_en_n) |=> $stable(dout));
endmodule

bind ofs_loader ofs_loader_chk #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .mode_ser(mode_ser), .cfg_n(cfg_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .shift_en_n(shift_en_n), .sdi(sdi), .dout(dout), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/ofs_loader_bench.sv
`timescale 1ns/1ps
module ofs_loader_bench;
  localparam int OFS_W = 14;
  localparam int BUS_W = 9;
  localparam int HI_W  = OFS_W - BUS_W;
  localparam int CW    = 2 * OFS_W;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n, ser_sel, cfg_n, wr_en_n, rd_en_n, shift_en_n, sdi;
  logic [BUS_W-1:0] din, dout;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic [OFS_W-1:0] m_ae, m_af;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 wclk = ~wclk;
  always #2.5 rclk = ~rclk;

  ofs_loader #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_ofs_loader (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .ser_sel(ser_sel), .cfg_n(cfg_n),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .shift_en_n(shift_en_n), .sdi(sdi),
    .din(din), .dout(dout), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] exp_part(input int k);
    case (k % 4)
      0:       return m_ae[BUS_W-1:0];
      1:       return BUS_W'(m_ae[OFS_W-1:BUS_W]);
      2:       return m_af[BUS_W-1:0];
      default: return BUS_W'(m_af[OFS_W-1:BUS_W]);
    endcase
  endfunction

  task automatic do_reset(input logic sel);
    mrst_n = 0; ser_sel = sel; cfg_n = 1; wr_en_n = 1; rd_en_n = 1;
    shift_en_n = 1; sdi = 0; din = '0;
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    repeat (3) @(negedge wclk);
    m_ae = OFS_W'(127); m_af = OFS_W'(127);
  endtask

  task automatic pwr(input logic [BUS_W-1:0] d);
    cfg_n = 0; wr_en_n = 0; din = d;
    @(negedge wclk);
    wr_en_n = 1;
  endtask

  task automatic prd();
    cfg_n = 0; rd_en_n = 0;
    @(negedge wclk);
    rd_en_n = 1;
  endtask

  task automatic release_cfg();
    cfg_n = 1;
    @(negedge wclk);
  endtask

  task automatic shift(input logic b);
    cfg_n = 1; wr_en_n = 1; shift_en_n = 0; sdi = b;
    @(negedge wclk);
    shift_en_n = 1;
  endtask

  task automatic model_shift(input logic b);
    logic [CW-1:0] c;
    c = {m_af, m_ae};
    c = {c[CW-2:0], b};
    m_af = c[CW-1:OFS_W]; m_ae = c[OFS_W-1:0];
  endtask

  // Writes all four parts of a pair; junk in unused upper din bits of high parts.
  task automatic write_pair(input logic [OFS_W-1:0] a, input logic [OFS_W-1:0] f);
    pwr(a[BUS_W-1:0]);
    pwr({4'b1010, a[OFS_W-1:BUS_W]});
    pwr(f[BUS_W-1:0]);
    pwr({4'b0101, f[OFS_W-1:BUS_W]});
    release_cfg();
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // ---------- parallel mode ----------
    do_reset(1'b0);
    chk("R2 ae reset", 32'(ae_ofs), 32'd127);
    chk("R2 af reset", 32'(af_ofs), 32'd127);
    chk("R2 dout reset", 32'(dout), 32'd0);
    // R2: read pointer starts at ae low part
    prd(); chk("R2 rptr home", 32'(dout), 32'(exp_part(0)));
    release_cfg();

    // R5/R7/R10 sweep over offset pairs
    for (int p = 0; p < 8; p++) begin
      logic [OFS_W-1:0] a, f;
      a = OFS_W'(p * 1237 + 5);
      f = OFS_W'(p * 4093 + 77 + p * p * 311);
      write_pair(a, f);
      m_ae = a; m_af = f;
      chk("R5 R10 ae after write", 32'(ae_ofs), 32'(m_ae));
      chk("R5 R10 af after write", 32'(af_ofs), 32'(m_af));
      for (int k = 0; k < 4; k++) begin
        prd();
        chk("R7 read part", 32'(dout), 32'(exp_part(k)));
      end
      release_cfg();
    end

    // R5: write pointer wraps after the fourth part
    pwr(9'h011); pwr(9'h002); pwr(9'h033); pwr(9'h004); pwr(9'h1F0);
    release_cfg();
    m_ae = {5'h02, 9'h1F0}; m_af = {5'h04, 9'h033};
    chk("R5 wrap ae", 32'(ae_ofs), 32'(m_ae));
    chk("R5 wrap af", 32'(af_ofs), 32'(m_af));

    // R7: read pointer wraps
    for (int k = 0; k < 5; k++) begin
      prd();
      chk("R7 read wrap", 32'(dout), 32'(exp_part(k)));
    end
    release_cfg();

    // R8: raising cfg_n mid-cycle sends write pointer home
    pwr(9'h0AA); pwr(9'h015);
    release_cfg();
    pwr(9'h155);
    release_cfg();
    m_ae = {5'h15, 9'h155};
    chk("R8 wptr home ae", 32'(ae_ofs), 32'(m_ae));
    chk("R8 wptr home af", 32'(af_ofs), 32'(m_af));
    prd(); prd();
    release_cfg();
    prd();
    chk("R8 rptr home", 32'(dout), 32'(exp_part(0)));
    release_cfg();

    // R9: dout holds without a read
    prd(); prd();
    chk("R9 before hold", 32'(dout), 32'(exp_part(1)));
    cfg_n = 1; rd_en_n = 0;
    repeat (3) @(negedge wclk);
    rd_en_n = 1;
    write_pair(14'h1234, 14'h0ABC);
    m_ae = 14'h1234; m_af = 14'h0ABC;
    chk("R9 dout held", 32'(dout), 32'({4'b0, 5'h15}));

    // R4: shifting in parallel mode has no effect
    for (int k = 0; k < 6; k++) shift(k[0]);
    chk("R4 no shift parallel ae", 32'(ae_ofs), 32'(m_ae));
    chk("R4 no shift parallel af", 32'(af_ofs), 32'(m_af));

    // R1: strap change after reset ignored
    ser_sel = 1;
    for (int k = 0; k < 4; k++) shift(1'b1);
    chk("R1 strap late ae", 32'(ae_ofs), 32'(m_ae));
    write_pair(14'h2001, 14'h1FFE);
    m_ae = 14'h2001; m_af = 14'h1FFE;
    chk("R1 still parallel ae", 32'(ae_ofs), 32'(m_ae));
    chk("R1 still parallel af", 32'(af_ofs), 32'(m_af));

    // ---------- serial mode ----------
    do_reset(1'b1);
    chk("R2 ae reset serial", 32'(ae_ofs), 32'd127);
    chk("R2 af reset serial", 32'(af_ofs), 32'd127);
    ser_sel = 0;

    // R6: parallel writes ignored; R1 strap change ignored
    write_pair(14'h3333, 14'h0001);
    chk("R6 R1 par ignored ae", 32'(ae_ofs), 32'd127);
    chk("R6 R1 par ignored af", 32'(af_ofs), 32'd127);

    // R3: per-shift check, three chain patterns
    for (int p = 0; p < 3; p++) begin
      logic [CW-1:0] pat;
      pat = CW'(p * 28'h2A5B3C7 + 28'h1234567);
      for (int i = CW - 1; i >= 0; i--) begin
        shift(pat[i]);
        model_shift(pat[i]);
        chk("R3 shift ae", 32'(ae_ofs), 32'(m_ae));
        chk("R3 shift af", 32'(af_ofs), 32'(m_af));
      end
      chk("R3 full chain", 32'({af_ofs, ae_ofs}), 32'(pat));
    end

    // R3: overrun drops oldest bits at af MSB end
    for (int i = 0; i < 5; i++) begin
      shift(i[0] ^ 1'b1);
      model_shift(i[0] ^ 1'b1);
    end
    chk("R3 overrun ae", 32'(ae_ofs), 32'(m_ae));
    chk("R3 overrun af", 32'(af_ofs), 32'(m_af));

    // R4: shift blocked when wr_en_n low or cfg_n low
    cfg_n = 1; wr_en_n = 0; shift_en_n = 0; sdi = ~m_ae[0];
    repeat (3) @(negedge wclk);
    wr_en_n = 1; shift_en_n = 1;
    chk("R4 blocked wr_en ae", 32'(ae_ofs), 32'(m_ae));
    cfg_n = 0; shift_en_n = 0;
    repeat (3) @(negedge wclk);
    shift_en_n = 1;
    release_cfg();
    chk("R4 blocked cfg ae", 32'(ae_ofs), 32'(m_ae));
    chk("R4 blocked cfg af", 32'(af_ofs), 32'(m_af));

    // R7: parallel readback works in serial mode
    for (int k = 0; k < 4; k++) begin
      prd();
      chk("R7 read in serial", 32'(dout), 32'(exp_part(k)));
    end
    release_cfg();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule